// File: doc/BRIEF.md
# Reservation-Wait Stall Controller

This block sits next to an in-order processor pipeline and handles the pair of "wait while a reservation holds" instructions. It recognises both variants from a 32-bit instruction word presented with an issue strobe. When one is accepted, it holds the hart stalled until one of three things happens: the load-reserved reservation is lost, a locally enabled interrupt becomes pending, or a wait timer runs out.

After the stall it raises a one-cycle completion pulse. This pulse is either a normal retire or an illegal-instruction indication. The trap logic, the snoop logic that clears the reservation, and the register file stay outside the block.

The short-timeout variant always arms a short timer. The no-timeout variant arms a long timer only below machine mode. Both timer lengths are parameters counted in clock cycles.

Top module: `rsw_stall_ctrl`

## Requirements
- R1: An instruction is accepted only when bits [6:0] = 1110011, bits [11:7] = 0, bits [14:12] = 0, bits [19:15] = 0, and bits [31:20] are either 000000011101 (short-timeout variant) or 000000001101 (no-timeout variant). Any other word presented with the issue strobe causes no stall and no completion.
- R2: `stall` is high in the issue cycle of an accepted instruction and in every wait cycle after it. It is low in reset, when idle, and in the completion cycle.
- R3: A low `resvValid` during a wait cycle ends the wait at the next clock edge with a normal retire.
- R4: A nonzero `ipBits & ieBits` during a wait cycle ends the wait at the next clock edge with a normal retire. Pending bits whose enable is zero do not end the wait.
- R5: With no wake event, the short-timeout variant completes SHORT_CYC+1 edges after its issue edge, whatever the privilege level.
- R6: The no-timeout variant times out LONG_CYC+1 edges after its issue edge when the privilege is below machine mode. In machine mode (privLvl = 2'b11) it never times out.
- R7: A timed-out wait raises `illegal` only when three things hold: the variant is no-timeout, privLvl is not 2'b11 (2'b01 supervisor, 2'b00 user), and `twBit` is 1. Every other completion raises `retire`.
- R8: A lost reservation or an enabled pending interrupt in the same cycle as timer expiry gives a normal retire, never `illegal`.
- R9: If the reservation is already lost, or an enabled interrupt is already pending, in the issue cycle, the instruction completes after exactly one wait cycle with a normal retire. This holds even if the condition clears by that wait cycle.
- R10: Each accepted instruction gives exactly one completion cycle, in which exactly one of `retire` and `illegal` is high. An issue strobe while a wait is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insnWord | input | 32 | Instruction word |
| issueStrobe | input | 1 | Instruction issues this cycle |
| resvValid | input | 1 | Load-reserved reservation is held |
| ipBits | input | IRQ_W | Interrupt pending bits |
| ieBits | input | IRQ_W | Interrupt enable bits |
| twBit | input | 1 | Timeout-wait trap enable for lower privileges |
| privLvl | input | 2 | Current privilege (11 M, 01 S, 00 U) |
| stall | output | 1 | Hold the hart |
| retire | output | 1 | Completion with normal retire |
| illegal | output | 1 | Completion with illegal-instruction indication |

## Verification
The hardest case to reach is the cycle where the timer expires and a wake event arrives in the very same cycle. Hitting it takes exact counting from the issue edge. The bench schedules reservation loss and interrupts by wait-cycle index, so it can place an event exactly on the expiry cycle. It also places events before the issue edge, which checks that a wake condition present at issue still counts after it clears.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int INSN_W = 32;
  localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
  localparam logic [11:0] IMM_SHORT  = 12'b000000011101;
  localparam logic [11:0] IMM_NOTO   = 12'b000000001101;
  localparam logic [1:0]  PRIV_M     = 2'b11;
  localparam logic [1:0]  PRIV_S     = 2'b01;
  localparam logic [1:0]  PRIV_U     = 2'b00;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} ctlState_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic load;   // accepted issue: capture variant, arm timer
    logic count;  // wait cycle with no wake
    logic clear;  // leaving wait: stop and clear the timer
  } tmrCmd_t;
endpackage

// File: rtl/rsw_decode.sv
module rsw_decode
  import rsw_pkg::*;
(
  input  logic [INSN_W-1:0] insnWord,
  output logic              hitShort,
  output logic              hitNoTo
);
  logic baseOk;

  always_comb begin
    baseOk   = (insnWord[6:0] == OPC_SYSTEM) && (insnWord[11:7] == 5'd0)
               && (insnWord[14:12] == 3'd0) && (insnWord[19:15] == 5'd0);
    hitShort = baseOk && (insnWord[31:20] == IMM_SHORT);
    hitNoTo  = baseOk && (insnWord[31:20] == IMM_NOTO);
  end
endmodule

// File: rtl/rsw_datapath.sv
module rsw_datapath
  import rsw_pkg::*;
#(
  parameter int SHORT_CYC = 6,
  parameter int LONG_CYC  = 20,
  parameter int IRQ_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  input  logic             hitNoTo,
  input  logic             resvValid,
  input  logic [IRQ_W-1:0] ipBits,
  input  logic [IRQ_W-1:0] ieBits,
  input  logic             twBit,
  input  logic [1:0]       privLvl,
  output logic             wake,
  output logic             trapNeeded
);
  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

  logic [CNT_W-1:0] cntQ, limitQ;
  logic armedQ, ntoQ, earlyQ;
  logic irqHit, resvLost, expired, timedOut, belowM;

  always_comb begin
    irqHit     = |(ipBits & ieBits);
    resvLost   = !resvValid;
    belowM     = (privLvl != PRIV_M);
    expired    = armedQ && (cntQ == limitQ);
    wake       = earlyQ || resvLost || irqHit || expired;
    timedOut   = !earlyQ && resvValid && !irqHit;
    trapNeeded = timedOut && ntoQ && belowM && twBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      limitQ <= '0;
      armedQ <= 1'b0;
      ntoQ   <= 1'b0;
      earlyQ <= 1'b0;
    end else if (cmd.load) begin
      cntQ   <= '0;
      limitQ <= hitNoTo ? LONG_LIM : SHORT_LIM;
      armedQ <= !hitNoTo || belowM;
      ntoQ   <= hitNoTo;
      earlyQ <= resvLost || irqHit;
    end else if (cmd.clear) begin
      cntQ   <= '0;
      armedQ <= 1'b0;
      earlyQ <= 1'b0;
    end else if (cmd.count && armedQ && !expired) begin
      cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/rsw_control.sv
module rsw_control
  import rsw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    issueStrobe,
  input  logic    isHit,
  input  logic    wake,
  input  logic    trapNeeded,
  output tmrCmd_t cmd,
  output logic    stall,
  output logic    retire,
  output logic    illegal
);
  ctlState_e stateQ, stateD;
  logic illQ, accept;

  always_comb begin
    accept    = (stateQ == ST_IDLE) && issueStrobe && isHit;
    cmd.load  = accept;
    cmd.count = (stateQ == ST_WAIT) && !wake;
    cmd.clear = (stateQ == ST_WAIT) && wake;
    stall     = accept || (stateQ == ST_WAIT);
    retire    = (stateQ == ST_DONE) && !illQ;
    illegal   = (stateQ == ST_DONE) && illQ;
    stateD    = stateQ;
    case (stateQ)
      ST_IDLE: if (accept) stateD = ST_WAIT;
      ST_WAIT: if (wake)   stateD = ST_DONE;
      default:             stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      illQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (cmd.clear) illQ <= trapNeeded;
    end
  end
endmodule

// File: rtl/rsw_stall_ctrl.sv
module rsw_stall_ctrl
  import rsw_pkg::*;
#(
  parameter int SHORT_CYC = 6,
  parameter int LONG_CYC  = 20,
  parameter int IRQ_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      insnWord,
  input  logic             issueStrobe,
  input  logic             resvValid,
  input  logic [IRQ_W-1:0] ipBits,
  input  logic [IRQ_W-1:0] ieBits,
  input  logic             twBit,
  input  logic [1:0]       privLvl,
  output logic             stall,
  output logic             retire,
  output logic             illegal
);
  logic hitShort, hitNoTo, wake, trapNeeded;
  tmrCmd_t cmd;

  rsw_decode u_dec (.insnWord(insnWord), .hitShort(hitShort), .hitNoTo(hitNoTo));

  rsw_datapath #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .IRQ_W(IRQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hitNoTo(hitNoTo), .resvValid(resvValid),
    .ipBits(ipBits), .ieBits(ieBits), .twBit(twBit), .privLvl(privLvl),
    .wake(wake), .trapNeeded(trapNeeded));

  rsw_control u_ctl (
    .clk(clk), .rstN(rstN), .issueStrobe(issueStrobe), .isHit(hitShort || hitNoTo),
    .wake(wake), .trapNeeded(trapNeeded), .cmd(cmd), .stall(stall),
    .retire(retire), .illegal(illegal));
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             resvValid,
  input logic [IRQ_W-1:0] ipBits,
  input logic [IRQ_W-1:0] ieBits,
  input logic             twBit,
  input logic [1:0]       privLvl,
  input logic             stall,
  input logic             retire,
  input logic             illegal
);
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(retire && illegal));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retire || illegal) |=> !(retire || illegal));

  p_done_follows_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (retire || illegal) |-> ($past(stall) && !stall));

  p_stall_drop_completes_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> (retire || illegal));

  p_resv_loss_wakes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall) && !resvValid) |=> (retire && !stall));

  p_irq_wakes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall) && (|(ipBits & ieBits))) |=> (retire && !stall));

  p_illegal_only_on_timeout_r7: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $past(twBit && (privLvl != 2'b11) && resvValid && !(|(ipBits & ieBits))));
endmodule

bind rsw_stall_ctrl rsw_checker #(.IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/sim_rsw_stall_ctrl.sv
module sim_rsw_stall_ctrl;
  localparam int SHORT_CYC = 6;
  localparam int LONG_CYC  = 20;
  localparam int IRQ_W     = 16;
  localparam logic [31:0] INSN_STO = 32'h01D00073;
  localparam logic [31:0] INSN_NTO = 32'h00D00073;

  typedef struct packed {
    logic [31:0] insn;
    logic [1:0]  priv;
    logic        tw;
    logic [7:0]  dropAt;  // wait-cycle index of reservation loss, 255 = never
    logic [7:0]  irqAt;   // wait-cycle index of interrupt, 255 = never
    logic [15:0] ie;
    logic        preDrop; // reservation lost only during the issue cycle
    logic        expIll;
    logic [7:0]  expLat;  // edges from issue edge to completion
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{INSN_STO, 2'b11, 1'b0, 8'd255, 8'd255, 16'hFFFF, 1'b0, 1'b0, 8'd7},   // R5 timeout in M
    '{INSN_STO, 2'b00, 1'b1, 8'd255, 8'd255, 16'hFFFF, 1'b0, 1'b0, 8'd7},   // R5 R7 short never traps
    '{INSN_NTO, 2'b00, 1'b1, 8'd255, 8'd255, 16'hFFFF, 1'b0, 1'b1, 8'd21},  // R6 R7 trap in U
    '{INSN_NTO, 2'b01, 1'b0, 8'd255, 8'd255, 16'hFFFF, 1'b0, 1'b0, 8'd21},  // R7 tw clear
    '{INSN_NTO, 2'b01, 1'b1, 8'd3,   8'd255, 16'hFFFF, 1'b0, 1'b0, 8'd4},   // R3 loss
    '{INSN_NTO, 2'b11, 1'b1, 8'd30,  8'd255, 16'hFFFF, 1'b0, 1'b0, 8'd31},  // R6 no timer in M
    '{INSN_STO, 2'b00, 1'b1, 8'd255, 8'd2,   16'hFFFF, 1'b0, 1'b0, 8'd3},   // R4 interrupt
    '{INSN_NTO, 2'b00, 1'b1, 8'd255, 8'd20,  16'hFFFF, 1'b0, 1'b0, 8'd21},  // R8 irq at expiry
    '{INSN_NTO, 2'b01, 1'b1, 8'd20,  8'd255, 16'hFFFF, 1'b0, 1'b0, 8'd21},  // R8 loss at expiry
    '{INSN_NTO, 2'b00, 1'b1, 8'd255, 8'd2,   16'h0000, 1'b0, 1'b1, 8'd21},  // R4 masked irq
    '{INSN_NTO, 2'b00, 1'b1, 8'd255, 8'd255, 16'hFFFF, 1'b1, 1'b0, 8'd1}    // R9 early loss
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] insnWord = '0;
  logic issueStrobe = 1'b0, resvValid = 1'b1, twBit = 1'b0;
  logic [IRQ_W-1:0] ipBits = '0, ieBits = '0;
  logic [1:0] privLvl = 2'b11;
  logic stall, retire, illegal;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rsw_stall_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .IRQ_W(IRQ_W)) u0 (
    .clk(clk), .rstN(rstN), .insnWord(insnWord), .issueStrobe(issueStrobe),
    .resvValid(resvValid), .ipBits(ipBits), .ieBits(ieBits), .twBit(twBit),
    .privLvl(privLvl), .stall(stall), .retire(retire), .illegal(illegal));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int lat = 0;
    int j = 0;
    bit done = 1'b0;
    bit stallOk = 1'b1;
    @(negedge clk);
    privLvl = v.priv; twBit = v.tw; ieBits = v.ie; ipBits = '0;
    resvValid = !v.preDrop;
    insnWord = v.insn; issueStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issueStrobe = 1'b0;
    resvValid = (v.dropAt == 8'd0) ? 1'b0 : 1'b1;
    if (v.irqAt == 8'd0) ipBits = 16'h0404;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (retire || illegal) done = 1'b1;
      else begin
        if (!stall) stallOk = 1'b0;
        j++;
        if (j == int'(v.dropAt)) resvValid = 1'b0;
        if (j == int'(v.irqAt))  ipBits = 16'h0404;
      end
    end
    $display("vector %0d", idx);
    check(stallOk, "R2 stall during wait", 0, 1);
    check(lat == int'(v.expLat), "R3/R4/R5/R6/R8/R9 latency", lat, int'(v.expLat));
    check(illegal == v.expIll && retire == !v.expIll, "R7 outcome", int'(illegal), int'(v.expIll));
    check(!stall, "R2 stall low at completion", int'(stall), 0);
    resvValid = 1'b1; ipBits = '0;
    @(posedge clk);
    @(negedge clk);
    check(!retire && !illegal, "R10 single pulse", int'(retire || illegal), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!stall && !retire && !illegal, "R2 R10 reset state", int'({stall, retire, illegal}), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R1: words that differ from the accepted encodings do nothing
    @(negedge clk);
    privLvl = 2'b00; twBit = 1'b1; ieBits = '1;
    insnWord = 32'h00D000F3; issueStrobe = 1'b1;  // rd nonzero
    check(!stall, "R1 rd nonzero", int'(stall), 0);
    @(negedge clk);
    insnWord = 32'h00000073;                       // other immediate
    check(!stall, "R1 other immediate", int'(stall), 0);
    @(negedge clk);
    insnWord = 32'h01D08073;                       // rs1 nonzero
    check(!stall, "R1 rs1 nonzero", int'(stall), 0);
    @(negedge clk);
    issueStrobe = 1'b0;
    cnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (stall || retire || illegal) cnt++;
    end
    check(cnt == 0, "R1 no activity", cnt, 0);

    // R10: issue during a wait is ignored; one completion only
    @(negedge clk);
    privLvl = 2'b01; twBit = 1'b0;
    insnWord = INSN_NTO; issueStrobe = 1'b1;
    @(negedge clk);
    issueStrobe = 1'b0;
    @(negedge clk);
    insnWord = INSN_STO; issueStrobe = 1'b1;
    @(negedge clk);
    issueStrobe = 1'b0;
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (retire || illegal) cnt++;
    end
    check(cnt == 1, "R10 issue while busy ignored", cnt, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule